// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Latched Error Flags

This block receives asynchronous serial characters on a single input line and hands each one to a host through a 16-bit receive buffer word. A built-in bit-rate generator scales the system clock in two stages. A prescaler selects clk/1, clk/8 or clk/32. A reloadable 8-bit down-counter then divides that by (n + 1) to make a sampling tick. Each bit period lasts sixteen ticks.

Each character has a start bit, 7, 8 or 9 data bits sent least significant bit first, an optional even or odd parity bit, and one or two stop bits. When the last stop bit has been sampled, the character moves from the shift register into the buffer. The parity, framing and overrun flags are set or cleared in that same cycle. The flags sit in the top nibble of the buffer word, together with a summary bit that is the OR of the three. A one-cycle interrupt request marks each transfer, except a transfer that overruns an unread character.

The host reads the buffer through two strobes: one for the low byte and one for the high byte. Both strobes count as a read of the character. Only the low-byte read clears the parity and framing flags. The overrun flag stays set until the receiver is switched off.

Top module: `sio_async_rx`

## Requirements
- R1: The bit period is 16 × (div_n_i + 1) × D clocks. D is 1 for src_sel_i = 00, 8 for 01, and 32 for 10 or 11. Characters sent at that rate are received intact.
- R2: A falling edge on the synchronised line starts a character only if the line is still low 8 ticks later. A low pulse shorter than half a bit produces no interrupt and leaves the buffer unchanged.
- R3: Data arrives LSB first. The length is set by char_len_i: 00 = 7 bits, 01 = 8, 10 = 9, 11 = 8. The data sits in rbuf_o[8:0], zero-extended, and rbuf_o[11:9] reads 0.
- R4: When par_en_i = 1, a parity bit follows the data. rbuf_o[14] (parity flag) is set on transfer when the count of ones in the data plus the parity bit is odd with par_odd_i = 0, or even with par_odd_i = 1. Otherwise it is cleared on transfer.
- R5: The frame has one stop bit, or two when two_stop_i = 1. rbuf_o[13] (framing flag) is set on transfer when any expected stop bit is sampled low. Otherwise it is cleared on transfer.
- R6: Each transfer raises rx_irq_o for exactly one clock, in the same cycle the buffer word changes.
- R7: If a character completes while the previous one is still unread, the new data overwrites the buffer, rbuf_o[12] (overrun flag) is set, and no interrupt is raised for that character.
- R8: rbuf_o[15] is 1 exactly when any of rbuf_o[14:12] is 1.
- R9: rd_lo_i clears the parity and framing flags and marks the buffer as read. rd_hi_i only marks the buffer as read. Neither strobe clears the overrun flag.
- R10: While rx_en_i = 0 or mode_sel_i = 000, all flags clear, the bit-rate generator and receiver halt, and incoming frames are ignored. The buffer data is kept.
- R11: After reset, rbuf_o is 0 and rx_irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd_i | input | 1 | Serial input line, idle high |
| mode_sel_i | input | 3 | Serial mode; 000 switches the receiver off |
| rx_en_i | input | 1 | Receive enable |
| src_sel_i | input | 2 | Prescaler select (/1, /8, /32) |
| div_n_i | input | 8 | Reload value n of the tick divider |
| char_len_i | input | 2 | Character length select |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | Odd parity when 1, even when 0 |
| two_stop_i | input | 1 | Two stop bits when 1 |
| rd_lo_i | input | 1 | Low-byte read strobe |
| rd_hi_i | input | 1 | High-byte read strobe |
| rbuf_o | output | 16 | Receive buffer word: data [8:0], flags [15:12] |
| rx_irq_o | output | 1 | Receive interrupt request pulse |

## Verification
A transfer lands in the middle of the last stop bit, about 2.5 clocks of synchroniser delay plus 8 ticks after that bit starts. The interrupt and the buffer word change on the same edge. The bench therefore holds the line idle for one more full bit period before it reads rbuf_o, and it counts interrupt pulses on falling edges, so the exact transfer cycle never matters. Read strobes and enable changes take effect on the next rising edge, so their effects are checked at the falling edge after that. The sweep covers every length, parity mode and stop count with clean, parity-corrupted and stop-corrupted frames, and runs at four prescaler and divider settings.

// File: rtl/sio_rx_pkg.sv
// Shared types and buffer-word field positions for the serial receiver.
// Assumes a 16-bit buffer word with data in the low bits.
package sio_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } rx_state_t;

    localparam int OVR_BIT = 12;
    localparam int FE_BIT  = 13;
    localparam int PE_BIT  = 14;
    localparam int SUM_BIT = 15;
endpackage

// File: rtl/sio_brg.sv
// Bit-rate generator: a selectable prescaler followed by a reload divider.
// Emits a one-cycle tick every PRE*(n+1) clocks while run is high.
// restart realigns both counters so that ticks are phased to a start edge.
module sio_brg #(
    parameter int DIV_W   = 8,
    parameter int MID_DIV = 8,
    parameter int MAX_DIV = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [1:0]       src_sel,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick_o
);
    localparam int PRE_W = $clog2(MAX_DIV);

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] pre_lim;
    logic             pre_en;
    logic [DIV_W-1:0] div_cnt;

    // Terminal count of the prescaler for the selected source.
    always_comb begin
        case (src_sel)
            2'b00:   pre_lim = '0;
            2'b01:   pre_lim = PRE_W'(MID_DIV - 1);
            default: pre_lim = PRE_W'(MAX_DIV - 1);
        endcase
        pre_en = (pre_cnt == pre_lim);
    end

    // Prescaler counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) pre_cnt <= '0;
        else if (pre_en)               pre_cnt <= '0;
        else                           pre_cnt <= pre_cnt + 1'b1;
    end

    // Reload divider: reloads to n after reaching zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) div_cnt <= div_n;
        else if (pre_en) begin
            if (div_cnt == '0) div_cnt <= div_n;
            else               div_cnt <= div_cnt - 1'b1;
        end
    end

    // Registered tick output.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) tick_o <= 1'b0;
        else                           tick_o <= pre_en && (div_cnt == '0);
    end

    // R10
    brg_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tick_o);
endmodule

// File: rtl/sio_rx_fsm.sv
// Frame receiver: detects the start edge, confirms it at half a bit,
// samples data, parity and stop bits at mid-bit (OVS ticks per bit)
// and pulses done_o with the character and its error status.
// Assumes rxd_i is already synchronised to clk.
module sio_rx_fsm
    import sio_rx_pkg::*;
#(
    parameter int MAX_CHAR = 9,
    parameter int OVS      = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                rxd_i,
    input  logic                tick,
    input  logic [1:0]          char_len,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                two_stop,
    output logic                restart_o,
    output logic                done_o,
    output logic [MAX_CHAR-1:0] data_o,
    output logic                perr_o,
    output logic                ferr_o
);
    localparam int TC_W = $clog2(OVS);
    localparam int BC_W = $clog2(MAX_CHAR + 1);
    localparam logic [TC_W-1:0] HALF_M1 = TC_W'(OVS / 2 - 1);
    localparam logic [TC_W-1:0] FULL_M1 = TC_W'(OVS - 1);

    rx_state_t       state;
    logic [TC_W-1:0] tcnt;
    logic [BC_W-1:0] bcnt;
    logic [BC_W-1:0] last_bit;
    logic            rxd_prev;
    logic            par_acc;

    // Index of the final data bit for the selected length.
    always_comb begin
        case (char_len)
            2'b00:   last_bit = BC_W'(6);
            2'b10:   last_bit = BC_W'(8);
            default: last_bit = BC_W'(7);
        endcase
    end

    // Start edge seen in idle realigns the bit-rate generator.
    assign restart_o = run && (state == ST_IDLE) && rxd_prev && !rxd_i;

    // Previous line level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) rxd_prev <= 1'b1;
        else        rxd_prev <= rxd_i;
    end

    // Frame sequencing, sampling and error evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            state   <= ST_IDLE;
            tcnt    <= '0;
            bcnt    <= '0;
            data_o  <= '0;
            par_acc <= 1'b0;
            perr_o  <= 1'b0;
            ferr_o  <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (restart_o) begin
                        state <= ST_START;
                        tcnt  <= '0;
                    end
                end
                ST_START: if (tick) begin
                    if (tcnt == HALF_M1) begin
                        tcnt <= '0;
                        if (!rxd_i) begin
                            state   <= ST_DATA;
                            bcnt    <= '0;
                            data_o  <= '0;
                            par_acc <= 1'b0;
                            perr_o  <= 1'b0;
                            ferr_o  <= 1'b0;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_DATA: if (tick) begin
                    if (tcnt == FULL_M1) begin
                        tcnt         <= '0;
                        data_o[bcnt] <= rxd_i;
                        par_acc      <= par_acc ^ rxd_i;
                        if (bcnt == last_bit) state <= par_en ? ST_PAR : ST_STOP1;
                        else                  bcnt  <= bcnt + 1'b1;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_PAR: if (tick) begin
                    if (tcnt == FULL_M1) begin
                        tcnt   <= '0;
                        perr_o <= ((par_acc ^ rxd_i) != par_odd);
                        state  <= ST_STOP1;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_STOP1: if (tick) begin
                    if (tcnt == FULL_M1) begin
                        tcnt   <= '0;
                        ferr_o <= !rxd_i;
                        if (two_stop) begin
                            state <= ST_STOP2;
                        end else begin
                            state  <= ST_IDLE;
                            done_o <= 1'b1;
                        end
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_STOP2: if (tick) begin
                    if (tcnt == FULL_M1) begin
                        tcnt   <= '0;
                        ferr_o <= ferr_o | !rxd_i;
                        state  <= ST_IDLE;
                        done_o <= 1'b1;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2
    start_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && $past(state) == ST_START) |-> $past(!rxd_i));
endmodule

// File: rtl/sio_rx_buf.sv
// Receive buffer and flag unit: captures each completed character,
// latches the parity, framing and overrun flags on that transfer, raises
// the interrupt pulse and applies the per-flag clearing rules.
// Assumes done is a single-cycle pulse.
module sio_rx_buf
    import sio_rx_pkg::*;
#(
    parameter int MAX_CHAR = 9,
    parameter int BUF_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active,
    input  logic                done,
    input  logic [MAX_CHAR-1:0] data,
    input  logic                perr,
    input  logic                ferr,
    input  logic                rd_lo,
    input  logic                rd_hi,
    output logic [BUF_W-1:0]    rbuf_o,
    output logic                irq_o
);
    logic [MAX_CHAR-1:0] dbuf;
    logic                full;
    logic                pe_f;
    logic                fe_f;
    logic                ovr_f;
    logic                rd_any;
    logic                unread;

    assign rd_any = rd_lo || rd_hi;
    assign unread = full && !rd_any;

    // Character storage, kept across disable.
    always_ff @(posedge clk) begin
        if (!rst_n)    dbuf <= '0;
        else if (done) dbuf <= data;
    end

    // Flags, unread marker and interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            full  <= 1'b0;
            pe_f  <= 1'b0;
            fe_f  <= 1'b0;
            ovr_f <= 1'b0;
            irq_o <= 1'b0;
        end else if (done) begin
            full  <= 1'b1;
            pe_f  <= perr;
            fe_f  <= ferr;
            ovr_f <= ovr_f | unread;
            irq_o <= !unread;
        end else begin
            irq_o <= 1'b0;
            if (rd_any) full <= 1'b0;
            if (rd_lo) begin
                pe_f <= 1'b0;
                fe_f <= 1'b0;
            end
        end
    end

    // Buffer word assembly.
    always_comb begin
        rbuf_o                = '0;
        rbuf_o[MAX_CHAR-1:0]  = dbuf;
        rbuf_o[OVR_BIT]       = ovr_f;
        rbuf_o[FE_BIT]        = fe_f;
        rbuf_o[PE_BIT]        = pe_f;
        rbuf_o[SUM_BIT]       = ovr_f | fe_f | pe_f;
    end

    // R6
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    // R6
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(done));
    // R9
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && ovr_f && rd_any) |=> ovr_f);
    // R10
    flags_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (rbuf_o[SUM_BIT:OVR_BIT] == 4'b0000));
endmodule

// File: rtl/sio_async_rx.sv
// Top level of the asynchronous serial receiver: line synchroniser,
// bit-rate generator, frame receiver and buffer/flag unit.
// Assumes rxd_i is asynchronous to clk and idles high.
module sio_async_rx #(
    parameter int DIV_W    = 8,
    parameter int MAX_CHAR = 9,
    parameter int OVS      = 16,
    parameter int BUF_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd_i,
    input  logic [2:0]       mode_sel_i,
    input  logic             rx_en_i,
    input  logic [1:0]       src_sel_i,
    input  logic [DIV_W-1:0] div_n_i,
    input  logic [1:0]       char_len_i,
    input  logic             par_en_i,
    input  logic             par_odd_i,
    input  logic             two_stop_i,
    input  logic             rd_lo_i,
    input  logic             rd_hi_i,
    output logic [BUF_W-1:0] rbuf_o,
    output logic             rx_irq_o
);
    logic                active;
    logic                rxd_meta;
    logic                rxd_sync;
    logic                tick;
    logic                restart;
    logic                done;
    logic [MAX_CHAR-1:0] data;
    logic                perr;
    logic                ferr;

    assign active = rx_en_i && (mode_sel_i != 3'b000);

    // Two-stage synchroniser for the serial line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxd_meta <= 1'b1;
            rxd_sync <= 1'b1;
        end else begin
            rxd_meta <= rxd_i;
            rxd_sync <= rxd_meta;
        end
    end

    sio_brg #(.DIV_W(DIV_W)) u_brg (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (active),
        .restart (restart),
        .src_sel (src_sel_i),
        .div_n   (div_n_i),
        .tick_o  (tick)
    );

    sio_rx_fsm #(.MAX_CHAR(MAX_CHAR), .OVS(OVS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (active),
        .rxd_i     (rxd_sync),
        .tick      (tick),
        .char_len  (char_len_i),
        .par_en    (par_en_i),
        .par_odd   (par_odd_i),
        .two_stop  (two_stop_i),
        .restart_o (restart),
        .done_o    (done),
        .data_o    (data),
        .perr_o    (perr),
        .ferr_o    (ferr)
    );

    sio_rx_buf #(.MAX_CHAR(MAX_CHAR), .BUF_W(BUF_W)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .done   (done),
        .data   (data),
        .perr   (perr),
        .ferr   (ferr),
        .rd_lo  (rd_lo_i),
        .rd_hi  (rd_hi_i),
        .rbuf_o (rbuf_o),
        .irq_o  (rx_irq_o)
    );
endmodule

// File: tb/sio_async_rx_tb.sv
// Self-checking bench: sweeps lengths, parity modes, stop counts and
// error injections, then checks overrun, read strobes, disable and rates.
module sio_async_rx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rxd = 1'b1;
    logic [2:0]  mode_sel = 3'b001;
    logic        rx_en = 1'b0;
    logic [1:0]  src_sel = 2'b00;
    logic [7:0]  div_n = 8'd1;
    logic [1:0]  char_len = 2'b01;
    logic        par_en = 1'b0;
    logic        par_odd = 1'b0;
    logic        two_stop = 1'b0;
    logic        rd_lo = 1'b0;
    logic        rd_hi = 1'b0;
    logic [15:0] rbuf;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int irq_cnt = 0;
    int bitclk = 32;

    always #5 clk = ~clk;

    sio_async_rx u_dut (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .mode_sel_i(mode_sel),
        .rx_en_i(rx_en), .src_sel_i(src_sel), .div_n_i(div_n),
        .char_len_i(char_len), .par_en_i(par_en), .par_odd_i(par_odd),
        .two_stop_i(two_stop), .rd_lo_i(rd_lo), .rd_hi_i(rd_hi),
        .rbuf_o(rbuf), .rx_irq_o(irq)
    );

    always @(negedge clk) if (rst_n && irq) irq_cnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input int cyc, input logic v);
        rxd = v;
        repeat (cyc) @(negedge clk);
    endtask

    // Sends one frame using the current configuration inputs.
    task automatic send(input logic [8:0] d, input bit bad_par, input bit bad_stop);
        int nb;
        logic p;
        nb = (char_len == 2'b00) ? 7 : (char_len == 2'b10) ? 9 : 8;
        hold(bitclk, 1'b0);
        p = 1'b0;
        for (int i = 0; i < nb; i++) begin
            hold(bitclk, d[i]);
            p = p ^ d[i];
        end
        if (par_en) hold(bitclk, p ^ par_odd ^ bad_par);
        if (two_stop) begin
            hold(bitclk, 1'b1);
            hold(bitclk, !bad_stop);
        end else begin
            hold(bitclk, !bad_stop);
        end
        hold(bitclk, 1'b1);
    endtask

    task automatic pulse_lo();
        rd_lo = 1'b1; @(negedge clk); rd_lo = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_hi();
        rd_hi = 1'b1; @(negedge clk); rd_hi = 1'b0; @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [8:0] vals [4];
        logic [8:0] mask;
        logic [8:0] dv;
        int nb, ic;
        bit bp, bs, pe_exp;
        vals[0] = 9'h000; vals[1] = 9'h1A5; vals[2] = 9'h15A; vals[3] = 9'h0FF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 rbuf", 32'(rbuf), 32'h0);
        chk("R11 irq", 32'(irq), 32'h0);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);

        // Sweep: R3 R4 R5 R6 R8 R9
        for (int len = 0; len < 3; len++)
        for (int pm = 0; pm < 3; pm++)
        for (int st = 0; st < 2; st++)
        for (int v = 0; v < 4; v++) begin
            char_len = 2'(len);
            par_en = (pm != 0);
            par_odd = (pm == 2);
            two_stop = st[0];
            nb = 7 + len;
            mask = 9'((1 << nb) - 1);
            dv = vals[v] & mask;
            bp = (v == 1) && par_en;
            bs = (v == 2);
            pe_exp = bp;
            ic = irq_cnt;
            send(dv, bp, bs);
            chk("R3 data", 32'(rbuf[11:0]), 32'(dv));
            chk("R4 parity flag", 32'(rbuf[14]), 32'(pe_exp));
            chk("R5 framing flag", 32'(rbuf[13]), 32'(bs));
            chk("R8 sum flag", 32'(rbuf[15]), 32'(pe_exp | bs));
            chk("R6 irq count", 32'(irq_cnt - ic), 32'd1);
            pulse_lo();
            chk("R9 low read clears", 32'(rbuf[15:12]), 32'h0);
        end

        // R7 overrun: two frames without a read
        char_len = 2'b01; par_en = 1'b0; two_stop = 1'b0;
        ic = irq_cnt;
        send(9'h033, 1'b0, 1'b0);
        send(9'h0C4, 1'b0, 1'b0);
        chk("R7 irq suppressed", 32'(irq_cnt - ic), 32'd1);
        chk("R7 data overwritten", 32'(rbuf[8:0]), 32'h0C4);
        chk("R7 overrun flag", 32'(rbuf[15:12]), 32'h9);
        pulse_lo();
        chk("R9 low read keeps overrun", 32'(rbuf[15:12]), 32'h9);
        pulse_hi();
        chk("R9 high read keeps overrun", 32'(rbuf[15:12]), 32'h9);
        ic = irq_cnt;
        send(9'h07E, 1'b0, 1'b0);
        chk("R7 read frame raises irq", 32'(irq_cnt - ic), 32'd1);
        chk("R7 overrun sticky", 32'(rbuf[12]), 32'h1);
        // R10 disable clears flags
        rx_en = 1'b0; @(negedge clk);
        chk("R10 enable off clears", 32'(rbuf[15:12]), 32'h0);
        chk("R10 data kept", 32'(rbuf[8:0]), 32'h07E);
        rx_en = 1'b1; @(negedge clk);
        send(9'h011, 1'b0, 1'b0);
        send(9'h022, 1'b0, 1'b0);
        chk("R7 overrun again", 32'(rbuf[12]), 32'h1);
        mode_sel = 3'b000; @(negedge clk);
        chk("R10 mode off clears", 32'(rbuf[15:12]), 32'h0);
        mode_sel = 3'b001; @(negedge clk);

        // R9 high read leaves parity flag
        par_en = 1'b1; par_odd = 1'b0;
        send(9'h05A, 1'b1, 1'b0);
        chk("R4 parity injected", 32'(rbuf[14]), 32'h1);
        pulse_hi();
        chk("R9 high read keeps parity", 32'(rbuf[14]), 32'h1);
        pulse_lo();
        chk("R9 low read clears parity", 32'(rbuf[14]), 32'h0);
        par_en = 1'b0;

        // R10 frames ignored while disabled
        rx_en = 1'b0; ic = irq_cnt;
        send(9'h0AB, 1'b0, 1'b0);
        chk("R10 no irq when off", 32'(irq_cnt - ic), 32'd0);
        chk("R10 buffer unchanged", 32'(rbuf[8:0]), 32'h05A);
        rx_en = 1'b1; repeat (4) @(negedge clk);

        // R2 short glitch rejected
        ic = irq_cnt;
        hold(6, 1'b0);
        hold(bitclk * 12, 1'b1);
        chk("R2 glitch no irq", 32'(irq_cnt - ic), 32'd0);
        chk("R2 glitch buffer unchanged", 32'(rbuf[8:0]), 32'h05A);

        // R1 rates
        for (int r = 0; r < 4; r++) begin
            case (r)
                0: begin src_sel = 2'b01; div_n = 8'd0; bitclk = 128; end
                1: begin src_sel = 2'b10; div_n = 8'd0; bitclk = 512; end
                2: begin src_sel = 2'b00; div_n = 8'd3; bitclk = 64;  end
                default: begin src_sel = 2'b11; div_n = 8'd0; bitclk = 512; end
            endcase
            ic = irq_cnt;
            send(9'(8'hA5 ^ 8'(r)), 1'b0, 1'b0);
            chk("R1 rate data", 32'(rbuf[8:0]), 32'(8'hA5 ^ 8'(r)));
            chk("R1 rate irq", 32'(irq_cnt - ic), 32'd1);
            pulse_lo();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule